// File: doc/BRIEF.md
# Auto-Baud Trainer with Lock Monitor

This block sits in front of a UART receiver and works out the bit period of the incoming serial stream by itself. A training window opens when the line is held low long enough to count as a break, or when the `train_req_i` pulse arrives. During the window, the block times the gaps between successive transitions on the synchronized RX line. Each gap of usable length goes into a five-entry window, and the running estimate is the median of that window. When enough consecutive gaps agree with the estimate, the block declares lock. It then hands a bit period, in clock ticks, to the receiver. That value can be either the raw median or the nearest entry of a standard rate table.

While locked, the block counts the framing-error pulses that the receiver reports. When the count passes a programmable limit, the block drops lock, records why, and waits for a proper retraining entry. A break or a training request seen while locked also starts a new training window, and that cause is recorded as well. A confidence value reported at each lock tells how many of the five window entries agreed with the chosen period.

Top module: `autobaud_trainer`

## Requirements
- R1: After reset `locked_o`, `bit_ticks_o`, `confidence_o` and `retrain_why_o` are all zero.
- R2: RX transitions are ignored until a training entry occurs. A training entry is either the line held low for `BRK_TICKS` (2048) clocks, or a one-cycle `train_req_i` pulse. Before such an entry `locked_o` stays 0.
- R3: A gap is the number of clocks between two consecutive RX transitions. A gap below `MIN_BIT` (4) or above `MAX_BIT` (255) is rejected: it is not stored in the window and it clears the agreement count. Any period latched without snapping lies within [`MIN_BIT`, `MAX_BIT`].
- R4: The estimate is the median of the last five accepted gaps.
- R5: Lock is declared once the window is full and `cfg_lock_n` consecutive accepted gaps each differ from the current estimate by at most estimate/16 (right shift by 4). Lock is never declared before that. The latched period is the median that includes the final gap.
- R6: With `cfg_snap_en` = 1, the period is the nearest of the tick counts for 115200, 57600, 38400, 19200 and 9600 baud at `CLK_HZ`; with the default `CLK_HZ` these are 10, 20, 30, 60 and 120. A tie goes to the shorter count. With `cfg_snap_en` = 0, the raw median is used.
- R7: `confidence_o` is the number of window entries, from 0 to 5, lying within median/16 of the median at the moment of lock. It is nonzero whenever the block is locked.
- R8: While locked, `frame_err_i` pulses are counted, and the count is cleared at each lock. The pulse that takes the count above `cfg_err_thr` drops lock and sets `retrain_why_o` = 1. The block then ignores RX transitions until a break or a training request arrives.
- R9: A break seen while locked drops lock and sets `retrain_why_o` = 2. A training request seen while locked drops lock and sets it to 3. In both cases measurement starts again at once, and `retrain_why_o` changes only together with a drop of lock.
- R10: `retrain_why_o` keeps its value until the next retrain decision. `bit_ticks_o` keeps its value while locked and after lock is dropped, until the next lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, assumed to run at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Synchronized serial receive line |
| frame_err_i | input | 1 | One-cycle framing-error pulse from the receiver |
| train_req_i | input | 1 | One-cycle request to open a training window |
| cfg_lock_n | input | 4 | Consecutive agreeing gaps needed to lock |
| cfg_err_thr | input | 8 | Framing errors tolerated while locked |
| cfg_snap_en | input | 1 | Snap the period to the standard rate table |
| bit_ticks_o | output | 12 | Bit period in clock ticks for the receiver |
| locked_o | output | 1 | Bit period is valid and being monitored |
| confidence_o | output | 3 | Window entries agreeing with the period at lock |
| retrain_why_o | output | 2 | Last retrain cause: 0 none, 1 error limit, 2 break, 3 request |

## Verification
The hardest case to reach is a noise capture that falls between agreeing gaps. A design that stores such a gap in the window looks the same at lock time as one that rejects it, because either way the agreement run restarts. The stimulus separates the two by locking with a count of one right after a two-clock glitch and then reading `confidence_o`: a stored glitch would leave only four agreeing entries. A second hard case is the wait state after the error limit. To expose it, the bench sends a full run of clean, regular transitions after the drop and shows that lock does not return until an explicit training request.

// File: rtl/abr_pkg.sv
package abr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEASURE,
    ST_LOCKED,
    ST_MONITOR,
    ST_RETRAIN_WAIT
  } abr_state_e;

  typedef enum logic [1:0] {
    WHY_NONE    = 2'd0,
    WHY_ERRLIM  = 2'd1,
    WHY_BREAK   = 2'd2,
    WHY_REQUEST = 2'd3
  } abr_why_e;

  localparam int unsigned STD_N = 5;

  // multiplier of 9600 baud for table slot k (slowest first)
  function automatic int unsigned std_mult(int unsigned k);
    case (k)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 6;
      default: return 12;
    endcase
  endfunction

  // rounded clock ticks per bit for table slot k
  function automatic int unsigned std_ticks(int unsigned clk_hz, int unsigned k);
    int unsigned m;
    m = std_mult(k);
    return (clk_hz + 4800 * m) / (9600 * m);
  endfunction

endpackage

// File: rtl/abr_edge_timer.sv
module abr_edge_timer #(
  parameter int CNT_W     = 12,
  parameter int BRK_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] gap_o,
  output logic             brk_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] BRK_AT  = CNT_W'(BRK_TICKS - 1);

  logic             rx_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o = rx_i ^ rx_q;
  assign gap_o  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
  assign brk_o  = !rx_i && !rx_q && (cnt_q == BRK_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      rx_q <= rx_i;
      if (edge_o)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/abr_median_win.sv
module abr_median_win #(
  parameter int NS     = 5,
  parameter int W      = 12,
  parameter int TOL_SH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  logic [W-1:0]             din_i,
  output logic                     full_o,
  output logic [W-1:0]             med_o,
  output logic [$clog2(NS+1)-1:0]  conf_o
);
  localparam int CF_W = $clog2(NS + 1);
  localparam int RK_W = $clog2(NS);
  localparam int MID  = (NS - 1) / 2;

  logic [W-1:0]    win_q [NS];
  logic [CF_W-1:0] fill_q;
  logic [RK_W-1:0] rank  [NS];
  logic [W-1:0]    tol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < NS; i++) win_q[i] <= '0;
    end else if (clr_i) begin
      fill_q <= '0;
    end else if (push_i) begin
      win_q[0] <= din_i;
      for (int i = 1; i < NS; i++) win_q[i] <= win_q[i-1];
      if (fill_q != CF_W'(NS)) fill_q <= fill_q + CF_W'(1);
    end
  end

  assign full_o = (fill_q == CF_W'(NS));

  // rank of each entry, ties broken by slot index: ranks form a permutation
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NS; j++) begin
        if ((win_q[j] < win_q[i]) || ((win_q[j] == win_q[i]) && (j < i)))
          rank[i] = rank[i] + RK_W'(1);
      end
    end
  end

  always_comb begin
    med_o = '0;
    for (int i = 0; i < NS; i++)
      if (rank[i] == RK_W'(MID)) med_o = win_q[i];
  end

  assign tol = med_o >> TOL_SH;

  always_comb begin
    conf_o = '0;
    for (int i = 0; i < NS; i++) begin
      if (((win_q[i] > med_o) ? (win_q[i] - med_o) : (med_o - win_q[i])) <= tol)
        conf_o = conf_o + CF_W'(1);
    end
  end
endmodule

// File: rtl/abr_snap.sv
module abr_snap
  import abr_pkg::*;
#(
  parameter int W      = 12,
  parameter int CLK_HZ = 1152000
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] tab [STD_N];

  // slot 0 holds the shortest period so that ties resolve toward it
  for (genvar k = 0; k < STD_N; k++) begin : g_tab
    assign tab[k] = W'(std_ticks(CLK_HZ, STD_N - 1 - k));
  end

  logic [W-1:0] best_d, d;

  always_comb begin
    snap_o = tab[0];
    best_d = (raw_i > tab[0]) ? raw_i - tab[0] : tab[0] - raw_i;
    for (int k = 1; k < STD_N; k++) begin
      d = (raw_i > tab[k]) ? raw_i - tab[k] : tab[k] - raw_i;
      if (d < best_d) begin
        best_d = d;
        snap_o = tab[k];
      end
    end
  end
endmodule

// File: rtl/autobaud_trainer.sv
module autobaud_trainer
  import abr_pkg::*;
#(
  parameter int CLK_HZ    = 1152000,
  parameter int CNT_W     = 12,
  parameter int NS        = 5,
  parameter int MIN_BIT   = 4,
  parameter int MAX_BIT   = 255,
  parameter int BRK_TICKS = 2048,
  parameter int TOL_SH    = 4,
  parameter int LOCKN_W   = 4,
  parameter int THR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_i,
  input  logic                    frame_err_i,
  input  logic                    train_req_i,
  input  logic [LOCKN_W-1:0]      cfg_lock_n,
  input  logic [THR_W-1:0]        cfg_err_thr,
  input  logic                    cfg_snap_en,
  output logic [CNT_W-1:0]        bit_ticks_o,
  output logic                    locked_o,
  output logic [$clog2(NS+1)-1:0] confidence_o,
  output logic [1:0]              retrain_why_o
);
  localparam int CF_W = $clog2(NS + 1);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_BIT);
  localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_BIT);

  logic             edge_w, brk_w, full_w;
  logic [CNT_W-1:0] gap_w, med_w, snap_w, diff_w, tol_w;
  logic [CF_W-1:0]  conf_w;

  abr_state_e          state_q, state_n;
  abr_why_e            why_q, why_n;
  logic [LOCKN_W-1:0]  cons_q, cons_n, cons_inc;
  logic                pend_q, pend_n;
  logic [THR_W-1:0]    errs_q, errs_n;
  logic [CNT_W-1:0]    ticks_q;
  logic [CF_W-1:0]     conf_q;
  logic                start_meas, in_meas, acc_w, consist_w, push_w, lock_hit, load_lock;

  abr_edge_timer #(.CNT_W(CNT_W), .BRK_TICKS(BRK_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .edge_o(edge_w), .gap_o(gap_w), .brk_o(brk_w)
  );

  abr_median_win #(.NS(NS), .W(CNT_W), .TOL_SH(TOL_SH)) u_win (
    .clk(clk), .rst_n(rst_n), .clr_i(start_meas), .push_i(push_w), .din_i(gap_w),
    .full_o(full_w), .med_o(med_w), .conf_o(conf_w)
  );

  abr_snap #(.W(CNT_W), .CLK_HZ(CLK_HZ)) u_snap (.raw_i(med_w), .snap_o(snap_w));

  assign in_meas   = (state_q == ST_MEASURE);
  assign acc_w     = edge_w && (gap_w >= MIN_L) && (gap_w <= MAX_L);
  assign diff_w    = (gap_w > med_w) ? gap_w - med_w : med_w - gap_w;
  assign tol_w     = med_w >> TOL_SH;
  assign consist_w = full_w && (diff_w <= tol_w);
  assign push_w    = in_meas && acc_w && !pend_q && !start_meas;
  assign cons_inc  = (cons_q == '1) ? cons_q : cons_q + LOCKN_W'(1);
  assign lock_hit  = push_w && consist_w && (cons_inc >= cfg_lock_n);

  // next-state logic
  always_comb begin
    state_n    = state_q;
    why_n      = why_q;
    start_meas = 1'b0;
    case (state_q)
      ST_IDLE, ST_RETRAIN_WAIT: begin
        if (brk_w || train_req_i) begin
          state_n    = ST_MEASURE;
          start_meas = 1'b1;
        end
      end
      ST_MEASURE: begin
        if (brk_w || train_req_i) start_meas = 1'b1;
        else if (pend_q)          state_n    = ST_LOCKED;
      end
      ST_LOCKED: state_n = ST_MONITOR;
      ST_MONITOR: begin
        if (brk_w) begin
          state_n    = ST_MEASURE;
          start_meas = 1'b1;
          why_n      = WHY_BREAK;
        end else if (frame_err_i && (errs_q == cfg_err_thr)) begin
          state_n = ST_RETRAIN_WAIT;
          why_n   = WHY_ERRLIM;
        end else if (train_req_i) begin
          state_n    = ST_MEASURE;
          start_meas = 1'b1;
          why_n      = WHY_REQUEST;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign load_lock = in_meas && (state_n == ST_LOCKED);

  always_comb begin
    cons_n = cons_q;
    pend_n = pend_q;
    if (start_meas) begin
      cons_n = '0;
      pend_n = 1'b0;
    end else if (in_meas && pend_q) begin
      pend_n = 1'b0;
    end else if (in_meas && edge_w) begin
      cons_n = (push_w && consist_w) ? cons_inc : '0;
      pend_n = lock_hit;
    end
  end

  always_comb begin
    errs_n = errs_q;
    if (state_q == ST_LOCKED)
      errs_n = '0;
    else if ((state_q == ST_MONITOR) && frame_err_i && (errs_q != '1))
      errs_n = errs_q + THR_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      why_q   <= WHY_NONE;
      cons_q  <= '0;
      pend_q  <= 1'b0;
      errs_q  <= '0;
      ticks_q <= '0;
      conf_q  <= '0;
    end else begin
      state_q <= state_n;
      why_q   <= why_n;
      cons_q  <= cons_n;
      pend_q  <= pend_n;
      errs_q  <= errs_n;
      if (load_lock) begin
        ticks_q <= cfg_snap_en ? snap_w : med_w;
        conf_q  <= conf_w;
      end
    end
  end

  assign bit_ticks_o   = ticks_q;
  assign confidence_o  = conf_q;
  assign retrain_why_o = why_q;
  assign locked_o      = (state_q == ST_LOCKED) || (state_q == ST_MONITOR);
endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int W       = 12,
  parameter int CF_W    = 3,
  parameter int MIN_BIT = 4,
  parameter int MAX_BIT = 255
) (
  input logic            clk,
  input logic            rst_n,
  input logic            locked_i,
  input logic            snap_en_i,
  input logic [W-1:0]    ticks_i,
  input logic [CF_W-1:0] conf_i,
  input logic [1:0]      why_i
);
  AST_RAW_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked_i) && !snap_en_i) |-> (ticks_i >= W'(MIN_BIT) && ticks_i <= W'(MAX_BIT))); // R3

  AST_LOCK_HAS_CONFIDENCE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_i |-> (conf_i != '0)); // R7

  AST_DROP_HAS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_i) |-> (why_i != 2'd0)); // R8

  AST_REASON_ONLY_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(why_i) |-> !locked_i); // R9

  AST_PERIOD_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_i && $past(locked_i)) |-> $stable(ticks_i)); // R10
endmodule

bind autobaud_trainer abr_checker #(
  .W(CNT_W), .CF_W(CF_W), .MIN_BIT(MIN_BIT), .MAX_BIT(MAX_BIT)
) u_abr_checker (
  .clk(clk), .rst_n(rst_n), .locked_i(locked_o), .snap_en_i(cfg_snap_en),
  .ticks_i(bit_ticks_o), .conf_i(confidence_o), .why_i(retrain_why_o)
);

// File: tb/autobaud_trainer_bench.sv
`timescale 1ns/1ps
module autobaud_trainer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx, ferr, treq, snap;
  logic [3:0]  lock_n;
  logic [7:0]  thr;
  logic [11:0] ticks;
  logic        locked;
  logic [2:0]  conf;
  logic [1:0]  why;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  autobaud_trainer u_autobaud_trainer (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .frame_err_i(ferr), .train_req_i(treq),
    .cfg_lock_n(lock_n), .cfg_err_thr(thr), .cfg_snap_en(snap),
    .bit_ticks_o(ticks), .locked_o(locked), .confidence_o(conf), .retrain_why_o(why)
  );

  // {gap, lock count, snap, expected period}
  localparam int VEC [6][4] = '{
    '{ 20, 2, 0,  20},
    '{ 21, 3, 1,  20},
    '{ 50, 2, 1,  60},
    '{118, 4, 1, 120},
    '{ 33, 1, 0,  33},
    '{ 12, 2, 1,  10}
  };

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gap(int len);
    repeat (len) @(negedge clk);
    rx = ~rx;
  endtask

  task automatic do_break();
    @(negedge clk);
    rx = 1'b0;
    repeat (2100) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic pulse_train();
    repeat (300) @(negedge clk);
    treq = 1'b1;
    @(negedge clk);
    treq = 1'b0;
  endtask

  task automatic pulse_ferr();
    @(negedge clk);
    ferr = 1'b1;
    @(negedge clk);
    ferr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx = 1'b1; ferr = 1'b0; treq = 1'b0;
    snap = 1'b0; lock_n = 4'd2; thr = 8'd2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 locked", locked, 0);
    chk("R1 period", ticks, 0);
    chk("R1 confidence", conf, 0);
    chk("R1 reason", why, 0);

    // R2: regular edges without a training entry
    for (int i = 0; i < 13; i++) gap(20);
    repeat (4) @(negedge clk);
    chk("R2 no entry no lock", locked, 0);

    // R5 R6 R7: vector table, each entered by a break
    for (int v = 0; v < 6; v++) begin
      lock_n = 4'(VEC[v][1]);
      snap   = VEC[v][2][0];
      do_break();
      for (int i = 0; i < 5 + VEC[v][1]; i++) begin
        repeat (VEC[v][0]) @(negedge clk);
        if (i == 4 + VEC[v][1]) chk("R5 not early", locked, 0);
        rx = ~rx;
      end
      repeat (4) @(negedge clk);
      chk("R5 locked", locked, 1);
      chk("R6 period", ticks, VEC[v][3]);
      chk("R7 confidence clean", conf, 5);
      chk("R9 break reason", why, (v == 0) ? 0 : 2);
    end

    // R4: median, not mean; R9 request reason
    lock_n = 4'd2; snap = 1'b0;
    pulse_train();
    chk("R9 request drops lock", locked, 0);
    chk("R9 request reason", why, 3);
    gap(1);
    gap(55); gap(60); gap(61); gap(62); gap(75); gap(61); gap(61);
    repeat (4) @(negedge clk);
    chk("R4 locked", locked, 1);
    chk("R4 median period", ticks, 61);
    chk("R7 confidence with outlier", conf, 4);

    // R3: a glitch is not stored in the window
    lock_n = 4'd1;
    do_break();
    chk("R9 break while locked", locked, 0);
    chk("R9 break reason", why, 2);
    for (int i = 0; i < 5; i++) gap(40);
    gap(2);
    gap(40);
    repeat (4) @(negedge clk);
    chk("R3 lock after glitch", locked, 1);
    chk("R3 glitch not stored", conf, 5);
    chk("R3 period", ticks, 40);

    // R3: a glitch clears the agreement run
    lock_n = 4'd3;
    pulse_train();
    gap(1);
    for (int i = 0; i < 7; i++) gap(40);
    gap(2);
    gap(40);
    repeat (4) @(negedge clk);
    chk("R3 run cleared", locked, 0);
    repeat (36) @(negedge clk);
    rx = ~rx;
    gap(40);
    repeat (4) @(negedge clk);
    chk("R3 relock", locked, 1);

    // R8: error limit, wait state, counter cleared on lock
    thr = 8'd2;
    pulse_ferr(); pulse_ferr();
    chk("R8 below limit", locked, 1);
    pulse_ferr();
    chk("R8 limit drops lock", locked, 0);
    chk("R8 reason", why, 1);
    chk("R10 period held", ticks, 40);
    for (int i = 0; i < 10; i++) gap(30);
    repeat (4) @(negedge clk);
    chk("R8 wait ignores edges", locked, 0);
    pulse_train();
    chk("R10 reason held", why, 1);
    gap(1);
    for (int i = 0; i < 8; i++) gap(30);
    repeat (4) @(negedge clk);
    chk("R8 relock", locked, 1);
    chk("R8 new period", ticks, 30);
    pulse_ferr(); pulse_ferr();
    chk("R8 count cleared", locked, 1);
    pulse_ferr();
    chk("R8 third error drops", locked, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule